// File: doc/BRIEF.md
# Bunch Crossing Timing Generator

This block turns the RF system clock into crossing-level timing for a trigger system. It divides the clock into bunch crossings, which are 7 clocks each at the short spacing and 21 clocks each at the long spacing. It raises a one-clock strobe when each crossing starts. Each crossing carries a crossing number and a turn number. The crossing number runs from 1 over one machine turn of 1113 clocks, and the turn number counts turns.

Crossing 1 is the first-crossing slot. It always sits inside the sync gap, and the first real beam crossing comes six crossings after it. Downstream logic reads a sync-gap flag and a live flag. A trigger decision is expected on every live crossing.

Two beam structures are supported:
- **Filled:** every slot holds a bunch. The sync gap is a programmable run of crossings that ends with the first-crossing slot.
- **Superbunch:** three trains are separated by three gaps. The sync gap runs from the end of the third train up to the first real crossing.

An external turn marker re-aligns the generator so that it restarts at crossing 1. A change of spacing is held back until the next turn boundary, so a turn is never split between two spacings.

Top module: `bx_timing_gen`

## Requirements
- R1: While `rst` is high (synchronous), the outputs read strobe 1, crossing number 1 and turn number 0. The spacing select is captured during reset. After release, the first crossing lasts a full crossing period.
- R2: `xing_strobe` is a one-clock pulse on the first clock of each crossing. It repeats every 7 clocks when the active spacing is 0 (short) and every 21 clocks when it is 1 (long).
- R3: The crossing number increments by one at each crossing start. It runs from 1 to 159 at short spacing and from 1 to 53 at long spacing, then wraps to 1.
- R4: The turn number increments by one (modulo 2^16) each time the crossing number wraps to 1.
- R5: `first_xing` is high for the whole of crossing number 1 and at no other time.
- R6: With `superbunch_sel`=0, the sync gap consists of crossing 1 and the `sync_len`-1 crossings before it at the end of the turn, which is every crossing n with n+`sync_len` > slots+1. With `sync_len`=0 there is no sync gap.
- R7: With `superbunch_sel`=1, the sync gap covers crossings 1 through 6 and every crossing after the last bunch of the third train.
  - The third train starts at crossing 7+floor(2*slots/3) and holds 36 bunches at short spacing or 12 at long spacing.
  - The gap is therefore crossings 149 to 159 at short spacing, and no crossing beyond 6 at long spacing.
- R8: `live` is the complement of `sync_gap` on every clock.
- R9: A new value of `spacing_sel` takes effect only at the next crossing-number wrap. It does not take effect mid-turn.
- R10: A `turn_mark` pulse sampled at a clock edge has three effects from that edge onward:
  - a new crossing 1 starts, with the strobe high;
  - the turn number increments;
  - the current `spacing_sel` is adopted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | RF system clock |
| rst | input | 1 | Synchronous active-high reset |
| spacing_sel | input | 1 | 0 selects short crossing spacing, 1 selects long |
| superbunch_sel | input | 1 | 0 selects the filled structure, 1 selects three trains |
| sync_len | input | 8 | Sync-gap length in crossings for the filled structure |
| turn_mark | input | 1 | External turn marker; restarts the count at crossing 1 |
| xing_strobe | output | 1 | One-clock pulse at the start of each crossing |
| xing_num | output | 8 | Crossing number within the turn |
| turn_num | output | 16 | Turn number |
| first_xing | output | 1 | High during the first-crossing slot |
| sync_gap | output | 1 | High during sync-gap crossings |
| live | output | 1 | High on crossings outside the sync gap |

## Verification
Every clock of at least one full turn is compared against arithmetic derived from the elapsed clock count. This is done for both spacings, both beam structures and two sync-gap lengths, including zero. A slot-count error, a wrong period or an off-by-one gap edge therefore shows up at a specific crossing.

A spacing change issued mid-turn separates an immediate switch from one deferred to the turn boundary. Marker pulses, one of them arriving together with a pending spacing change, separate a proper re-alignment from a drift and show whether the turn number increments on re-alignment.

// File: rtl/tcg_pkg.sv
package tcg_pkg;
    localparam int XNUM_W = 8;
    localparam int TURN_W = 16;
    localparam int DIV_W  = 5;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } phase_st_t;

    typedef struct packed {
        logic [XNUM_W-1:0] xnum;
        logic [TURN_W-1:0] turn;
        logic              slow;
    } count_st_t;
endpackage

// File: rtl/xing_phase.sv
module xing_phase
    import tcg_pkg::*;
#(
    parameter int FAST_CLKS = 7,
    parameter int SLOW_CLKS = 21
) (
    input  logic clk,
    input  logic rst,
    input  logic slow,
    input  logic resync,
    output logic strobe,
    output logic last
);
    localparam logic [DIV_W-1:0] FAST_END = DIV_W'(FAST_CLKS - 1);
    localparam logic [DIV_W-1:0] SLOW_END = DIV_W'(SLOW_CLKS - 1);

    phase_st_t st_d, st_q;
    logic [DIV_W-1:0] end_cnt;

    always_comb begin
        end_cnt = slow ? SLOW_END : FAST_END;
        last    = (st_q.div == end_cnt);
        strobe  = (st_q.div == '0);
        st_d    = st_q;
        if (rst || resync || last) begin
            st_d.div = '0;
        end else begin
            st_d.div = st_q.div + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        strobe && !resync |=> !strobe);  // R2
    AST_LAST_TO_STROBE: assert property (@(posedge clk) disable iff (rst)
        last |=> strobe);  // R2
endmodule

// File: rtl/xing_count.sv
module xing_count
    import tcg_pkg::*;
#(
    parameter int FAST_SLOTS = 159,
    parameter int SLOW_SLOTS = 53
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spacing_sel,
    input  logic              resync,
    input  logic              adv,
    output logic [XNUM_W-1:0] xnum,
    output logic [TURN_W-1:0] turn,
    output logic              slow
);
    localparam logic [XNUM_W-1:0] FAST_TOP = XNUM_W'(FAST_SLOTS);
    localparam logic [XNUM_W-1:0] SLOW_TOP = XNUM_W'(SLOW_SLOTS);

    count_st_t st_d, st_q;
    logic [XNUM_W-1:0] top;
    logic              wrap;

    always_comb begin
        top  = st_q.slow ? SLOW_TOP : FAST_TOP;
        wrap = adv && (st_q.xnum == top);
        st_d = st_q;
        if (rst) begin
            st_d.xnum = XNUM_W'(1);
            st_d.turn = '0;
            st_d.slow = spacing_sel;
        end else if (resync || wrap) begin
            st_d.xnum = XNUM_W'(1);
            st_d.turn = st_q.turn + 1'b1;
            st_d.slow = spacing_sel;
        end else if (adv) begin
            st_d.xnum = st_q.xnum + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign xnum = st_q.xnum;
    assign turn = st_q.turn;
    assign slow = st_q.slow;

    AST_XNUM_RANGE: assert property (@(posedge clk) disable iff (rst)
        (xnum != '0) && (xnum <= top));  // R3
    AST_TURN_STEP: assert property (@(posedge clk) disable iff (rst)
        adv && (xnum == top) && !resync |=> turn == TURN_W'($past(turn) + 1'b1));  // R4
    AST_SPACING_HOLD: assert property (@(posedge clk) disable iff (rst)
        !resync && !(adv && (xnum == top)) |=> $stable(slow));  // R9
    AST_RESYNC_START: assert property (@(posedge clk) disable iff (rst)
        resync |=> xnum == XNUM_W'(1));  // R10
endmodule

// File: rtl/sync_gap_decode.sv
module sync_gap_decode
    import tcg_pkg::*;
#(
    parameter int FAST_SLOTS    = 159,
    parameter int SLOW_SLOTS    = 53,
    parameter int FAST_BUNCHES  = 36,
    parameter int SLOW_BUNCHES  = 12,
    parameter int TRAINS        = 3,
    parameter int FIRST_TO_REAL = 6
) (
    input  logic              slow,
    input  logic              superbunch,
    input  logic [7:0]        gap_len,
    input  logic [XNUM_W-1:0] xnum,
    output logic              gap
);
    localparam int FAST_LAST = FIRST_TO_REAL + ((TRAINS - 1) * FAST_SLOTS) / TRAINS + FAST_BUNCHES;
    localparam int SLOW_LAST = FIRST_TO_REAL + ((TRAINS - 1) * SLOW_SLOTS) / TRAINS + SLOW_BUNCHES;

    logic [XNUM_W:0]   lim, sum;
    logic [XNUM_W-1:0] last_bunch;
    logic              sb_gap, fill_gap;

    always_comb begin
        lim        = slow ? (XNUM_W+1)'(SLOW_SLOTS + 1) : (XNUM_W+1)'(FAST_SLOTS + 1);
        last_bunch = slow ? XNUM_W'(SLOW_LAST) : XNUM_W'(FAST_LAST);
        sum        = {1'b0, xnum} + (XNUM_W+1)'(gap_len);
        sb_gap     = (xnum <= XNUM_W'(FIRST_TO_REAL)) || (xnum > last_bunch);
        fill_gap   = (gap_len != '0) && ((xnum == XNUM_W'(1)) || (sum > lim));
        gap        = superbunch ? sb_gap : fill_gap;
    end
endmodule

// File: rtl/bx_timing_gen.sv
module bx_timing_gen
    import tcg_pkg::*;
#(
    parameter int FAST_CLKS     = 7,
    parameter int SLOW_CLKS     = 21,
    parameter int FAST_SLOTS    = 159,
    parameter int SLOW_SLOTS    = 53,
    parameter int FAST_BUNCHES  = 36,
    parameter int SLOW_BUNCHES  = 12,
    parameter int TRAINS        = 3,
    parameter int FIRST_TO_REAL = 6
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        spacing_sel,
    input  logic        superbunch_sel,
    input  logic [7:0]  sync_len,
    input  logic        turn_mark,
    output logic        xing_strobe,
    output logic [7:0]  xing_num,
    output logic [15:0] turn_num,
    output logic        first_xing,
    output logic        sync_gap,
    output logic        live
);
    logic              slow_w, last_w, gap_w;
    logic [XNUM_W-1:0] xnum_w;
    logic [TURN_W-1:0] turn_w;

    xing_phase #(
        .FAST_CLKS(FAST_CLKS),
        .SLOW_CLKS(SLOW_CLKS)
    ) u_phase (
        .clk   (clk),
        .rst   (rst),
        .slow  (slow_w),
        .resync(turn_mark),
        .strobe(xing_strobe),
        .last  (last_w)
    );

    xing_count #(
        .FAST_SLOTS(FAST_SLOTS),
        .SLOW_SLOTS(SLOW_SLOTS)
    ) u_count (
        .clk        (clk),
        .rst        (rst),
        .spacing_sel(spacing_sel),
        .resync     (turn_mark),
        .adv        (last_w),
        .xnum       (xnum_w),
        .turn       (turn_w),
        .slow       (slow_w)
    );

    sync_gap_decode #(
        .FAST_SLOTS   (FAST_SLOTS),
        .SLOW_SLOTS   (SLOW_SLOTS),
        .FAST_BUNCHES (FAST_BUNCHES),
        .SLOW_BUNCHES (SLOW_BUNCHES),
        .TRAINS       (TRAINS),
        .FIRST_TO_REAL(FIRST_TO_REAL)
    ) u_gap (
        .slow      (slow_w),
        .superbunch(superbunch_sel),
        .gap_len   (sync_len),
        .xnum      (xnum_w),
        .gap       (gap_w)
    );

    assign xing_num   = xnum_w;
    assign turn_num   = turn_w;
    assign first_xing = (xnum_w == XNUM_W'(1));
    assign sync_gap   = gap_w;
    assign live       = !gap_w;

    AST_FIRST_AT_STROBE: assert property (@(posedge clk) disable iff (rst)
        $rose(first_xing) |-> xing_strobe);  // R5
    AST_FIRST_IN_GAP: assert property (@(posedge clk) disable iff (rst)
        superbunch_sel && first_xing |-> sync_gap && !live);  // R7
endmodule

// File: tb/sim_bx_timing_gen.sv
module sim_bx_timing_gen;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        spacing_sel = 1'b0;
    logic        superbunch_sel = 1'b0;
    logic [7:0]  sync_len = 8'd0;
    logic        turn_mark = 1'b0;
    logic        xing_strobe, first_xing, sync_gap, live;
    logic [7:0]  xing_num;
    logic [15:0] turn_num;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    int t_rel, turn_base;
    logic cur_slow, sel_prev, mark_prev, next_sel, next_mark;
    string sect;

    bx_timing_gen u0 (
        .clk(clk), .rst(rst), .spacing_sel(spacing_sel), .superbunch_sel(superbunch_sel),
        .sync_len(sync_len), .turn_mark(turn_mark), .xing_strobe(xing_strobe),
        .xing_num(xing_num), .turn_num(turn_num), .first_xing(first_xing),
        .sync_gap(sync_gap), .live(live)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int cpx(input logic s);
        return s ? 21 : 7;
    endfunction

    function automatic int slots(input logic s);
        return s ? 53 : 159;
    endfunction

    function automatic bit exp_gap(input int x, input logic s, input logic sb, input int len);
        if (sb) return (x <= 6) || (x > (s ? 53 : 148));
        return (len != 0) && ((x == 1) || (x + len > slots(s) + 1));
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s t=%0d: actual=%0d expected=%0d", sect, req, t_rel, act, exp);
        end
    endtask

    task automatic cycle();
        int x;
        bit g;
        @(negedge clk);
        if (mark_prev) begin
            t_rel = 0; turn_base++; cur_slow = sel_prev;
        end else if (t_rel == cpx(cur_slow) * slots(cur_slow)) begin
            t_rel = 0; turn_base++; cur_slow = sel_prev;
        end
        x = t_rel / cpx(cur_slow) + 1;
        g = exp_gap(x, cur_slow, superbunch_sel, int'(sync_len));
        chk("R2 strobe", int'(xing_strobe), int'(t_rel % cpx(cur_slow) == 0));
        chk("R3 xing_num", int'(xing_num), x);
        chk("R4 turn_num", int'(turn_num), turn_base & 16'hFFFF);
        chk("R5 first_xing", int'(first_xing), int'(x == 1));
        if (superbunch_sel) chk("R7 sync_gap", int'(sync_gap), int'(g));
        else                chk("R6 sync_gap", int'(sync_gap), int'(g));
        chk("R8 live", int'(live), int'(!g));
        spacing_sel = next_sel;
        turn_mark   = next_mark;
        sel_prev    = next_sel;
        mark_prev   = next_mark;
        t_rel++;
    endtask

    task automatic do_reset(input logic s, input logic sb, input int len);
        rst = 1'b1; spacing_sel = s; superbunch_sel = sb; sync_len = 8'(len);
        turn_mark = 1'b0; next_sel = s; next_mark = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1 reset strobe", int'(xing_strobe), 1);
        chk("R1 reset xing_num", int'(xing_num), 1);
        chk("R1 reset turn_num", int'(turn_num), 0);
        rst = 1'b0;
        t_rel = 1; turn_base = 0; cur_slow = s; sel_prev = s; mark_prev = 1'b0;
    endtask

    initial begin
        sect = "R1 slow start";
        do_reset(1'b1, 1'b0, 4);
        for (int i = 0; i < 1200; i++) cycle();

        sect = "R6 fast filled len8";
        do_reset(1'b0, 1'b0, 8);
        for (int i = 0; i < 2300; i++) cycle();

        sect = "R6 fast filled len0";
        do_reset(1'b0, 1'b0, 0);
        for (int i = 0; i < 1200; i++) cycle();

        sect = "R6 fast filled len1";
        do_reset(1'b0, 1'b0, 1);
        for (int i = 0; i < 1200; i++) cycle();

        sect = "R7 fast superbunch";
        do_reset(1'b0, 1'b1, 0);
        for (int i = 0; i < 2300; i++) cycle();

        sect = "R6 slow filled len3";
        do_reset(1'b1, 1'b0, 3);
        for (int i = 0; i < 2300; i++) cycle();

        sect = "R7 slow superbunch";
        do_reset(1'b1, 1'b1, 0);
        for (int i = 0; i < 1200; i++) cycle();

        sect = "R9 spacing change";
        do_reset(1'b0, 1'b0, 5);
        for (int i = 0; i < 400; i++) cycle();
        next_sel = 1'b1;
        for (int i = 0; i < 2600; i++) cycle();
        next_sel = 1'b0;
        for (int i = 0; i < 1300; i++) cycle();

        sect = "R10 turn marker";
        do_reset(1'b0, 1'b1, 0);
        for (int i = 0; i < 300; i++) cycle();
        next_mark = 1'b1;
        cycle();
        next_mark = 1'b0;
        for (int i = 0; i < 500; i++) cycle();
        next_sel = 1'b1;
        for (int i = 0; i < 20; i++) cycle();
        next_mark = 1'b1;
        cycle();
        next_mark = 1'b0;
        for (int i = 0; i < 1300; i++) cycle();

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule